// File: doc/BRIEF.md
# VBI Line Pass/Blank Controller

This block sits in the datapath of a video encoder. For each video line it decides whether the vertical blanking interval (VBI) content on that line is passed through or replaced with blanking levels. A timing generator pulses `line_start` on the first sample of each line and presents the line number and field at the same time. On that cycle the block reads the standard select, the two VBI enables, the timing mode, the blank-control bit and the CGMS enable, and registers one decision for the whole line. Control changes made later in the line wait for the next line boundary.

The registered decision has three parts:
- a pass flag;
- a force flag, which tells the EAV/SAV inserter to set the blanking bit;
- a clear flag, which tells it to drop the blanking bit so the line is treated as active.

Luma and chroma samples leave one cycle after they enter. They are either unchanged or replaced by the blank levels.

Line numbers count within the field for the interlaced standards and within the frame for the progressive ones.

Top module: `vbi_gate`

## Requirements
- R1: The VBI window is set by `std_sel`. Code 0 (525i) covers lines 10..20, code 1 (625i) covers lines 7..22, code 2 (525p) covers lines 13..42, and code 3 (625p) covers lines 6..43. All bounds are inclusive.
- R2: On a line outside the window, `line_pass`=1, `eav_force`=0 and `eav_clear`=0, and samples pass unchanged.
- R3: The progressive standards (codes 2 and 3) use `vbi_en_hd`, and the interlaced standards (codes 0 and 1) use `vbi_en_sd`. When the selected enable is 0, an in-window line is blanked unless R8 applies. The enable that is not selected has no effect.
- R4: In timing mode 0 (master) and mode 1 (slave 0), an in-window line passes when the selected VBI enable is 1.
- R5: In timing modes 2 and 3 (slave 1 and slave 2), an in-window line passes only when both the selected VBI enable and `blank_ctl_en` are 1.
- R6: `eav_clear`=1 exactly on an in-window line that passes while the timing mode is 1.
- R7: `eav_force`=1 exactly on an in-window line that is blanked. `eav_force` and `eav_clear` are never 1 together.
- R8: When `cgms_en`=1, the CGMS line passes whatever the VBI enable, timing mode and blank control are. The CGMS line is:
  - line 20 in either field for 525i;
  - line 22 in field 0 only for 625i;
  - line 41 for 525p;
  - line 43 for 625p.
- R9: `out_y`/`out_c` follow `in_y`/`in_c` one cycle later on a passed line. On a blanked line they are 0x10/0x80 for every sample, including the sample that arrives with `line_start`.
- R10: The decision is captured only in a cycle where `line_start`=1 and appears on the decision outputs one cycle later. Changes to the line number, field or any control in other cycles do not alter the current line's decision or its sample handling.
- R11: While reset is asserted, `line_pass`=1, `eav_force`=0, `eav_clear`=0, `out_y`=0x10 and `out_c`=0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | First sample of a line; decision capture strobe |
| line_num | input | 11 | Line number for the line that is starting |
| field | input | 1 | Field of the line that is starting (interlaced) |
| std_sel | input | 2 | Standard: 0 525i, 1 625i, 2 525p, 3 625p |
| vbi_en_hd | input | 1 | VBI enable for progressive standards |
| vbi_en_sd | input | 1 | VBI enable for interlaced standards |
| timing_mode | input | 2 | 0 master, 1 slave 0, 2 slave 1, 3 slave 2 |
| blank_ctl_en | input | 1 | Blank-control enable for slave 1/2 |
| cgms_en | input | 1 | CGMS line keeps passing when set |
| in_y | input | 8 | Luma sample in |
| in_c | input | 8 | Chroma sample in |
| line_pass | output | 1 | Current line passes |
| eav_force | output | 1 | Inserter must set the blanking bit |
| eav_clear | output | 1 | Inserter must clear the blanking bit |
| out_y | output | 8 | Luma sample out |
| out_c | output | 8 | Chroma sample out |

## Verification
Each result has a fixed arrival cycle after a line strobe:
- The three decision flags appear in the cycle after the `line_start` edge.
- The sample driven with the strobe appears on `out_y`/`out_c` in that same following cycle, under the new decision.

The bench drives every input at a falling edge and samples outputs at the next falling edge. This puts each comparison exactly one rising edge after its stimulus. To probe the hold-until-boundary rule, the bench then changes every control and the line number in the middle of the line. One edge later it checks that both the decision and the handling of the next sample still follow the earlier strobe.

// File: rtl/vbi_gate_pkg.sv
package vbi_gate_pkg;

    typedef enum logic [1:0] {
        STD_525I = 2'd0,
        STD_625I = 2'd1,
        STD_525P = 2'd2,
        STD_625P = 2'd3
    } vid_std_e;

    typedef enum logic [1:0] {
        TM_MASTER = 2'd0,
        TM_SLAVE0 = 2'd1,
        TM_SLAVE1 = 2'd2,
        TM_SLAVE2 = 2'd3
    } tmode_e;

    typedef struct packed {
        logic pass;
        logic in_win;
        logic eav_force;
        logic eav_clear;
    } line_dec_t;

    function automatic logic is_progressive(vid_std_e s);
        return (s == STD_525P) || (s == STD_625P);
    endfunction

endpackage

// File: rtl/vbi_window.sv
module vbi_window
    import vbi_gate_pkg::*;
#(
    parameter int LW        = 11,
    parameter int LO_525I   = 10,
    parameter int HI_525I   = 20,
    parameter int LO_625I   = 7,
    parameter int HI_625I   = 22,
    parameter int LO_525P   = 13,
    parameter int HI_525P   = 42,
    parameter int LO_625P   = 6,
    parameter int HI_625P   = 43,
    parameter int CG_525I   = 20,
    parameter int CG_625I   = 22,
    parameter int CG_525P   = 41,
    parameter int CG_625P   = 43
) (
    input  logic [LW-1:0] line_num,
    input  logic          field,
    input  vid_std_e      std,
    output logic          in_win,
    output logic          cgms_line
);
    localparam int NSTD = 4;
    localparam logic [LW-1:0] LO_TAB [NSTD] = '{LW'(LO_525I), LW'(LO_625I), LW'(LO_525P), LW'(LO_625P)};
    localparam logic [LW-1:0] HI_TAB [NSTD] = '{LW'(HI_525I), LW'(HI_625I), LW'(HI_525P), LW'(HI_625P)};
    localparam logic [LW-1:0] CG_TAB [NSTD] = '{LW'(CG_525I), LW'(CG_625I), LW'(CG_525P), LW'(CG_625P)};

    logic [NSTD-1:0] win_hit;
    logic [NSTD-1:0] cg_hit;

    for (genvar g = 0; g < NSTD; g++) begin : g_std
        assign win_hit[g] = (line_num >= LO_TAB[g]) && (line_num <= HI_TAB[g]);
        assign cg_hit[g]  = (line_num == CG_TAB[g]);
    end

    always_comb begin
        in_win    = win_hit[std];
        cgms_line = cg_hit[std];
        // 625i carries its CGMS/WSS line in the first field only
        if (std == STD_625I && field) cgms_line = 1'b0;
    end
endmodule

// File: rtl/vbi_policy.sv
module vbi_policy
    import vbi_gate_pkg::*;
(
    input  logic      in_win,
    input  logic      cgms_line,
    input  vid_std_e  std,
    input  tmode_e    tmode,
    input  logic      vbi_en_hd,
    input  logic      vbi_en_sd,
    input  logic      blank_ctl_en,
    input  logic      cgms_en,
    output line_dec_t dec
);
    logic vbi_on;
    logic mode_ok;
    logic cgms_keep;

    always_comb begin
        vbi_on = is_progressive(std) ? vbi_en_hd : vbi_en_sd;
        unique case (tmode)
            TM_MASTER, TM_SLAVE0: mode_ok = vbi_on;
            default:              mode_ok = vbi_on && blank_ctl_en;
        endcase
        cgms_keep = cgms_en && cgms_line;

        dec.in_win    = in_win;
        dec.pass      = !in_win || mode_ok || cgms_keep;
        dec.eav_force = in_win && !dec.pass;
        dec.eav_clear = in_win && dec.pass && (tmode == TM_SLAVE0);
    end
endmodule

// File: rtl/vbi_sample_mux.sv
module vbi_sample_mux #(
    parameter int              DW      = 8,
    parameter logic [DW-1:0]   BLANK_Y = DW'(8'h10),
    parameter logic [DW-1:0]   BLANK_C = DW'(8'h80)
) (
    input  logic          pass,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] c_in,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] c_out
);
    always_comb begin
        y_out = pass ? y_in : BLANK_Y;
        c_out = pass ? c_in : BLANK_C;
    end
endmodule

// File: rtl/vbi_gate.sv
module vbi_gate
    import vbi_gate_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic [LW-1:0] line_num,
    input  logic          field,
    input  logic [1:0]    std_sel,
    input  logic          vbi_en_hd,
    input  logic          vbi_en_sd,
    input  logic [1:0]    timing_mode,
    input  logic          blank_ctl_en,
    input  logic          cgms_en,
    input  logic [DW-1:0] in_y,
    input  logic [DW-1:0] in_c,
    output logic          line_pass,
    output logic          eav_force,
    output logic          eav_clear,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_c
);
    localparam logic [DW-1:0] BLANK_Y = DW'(8'h10);
    localparam logic [DW-1:0] BLANK_C = DW'(8'h80);
    localparam line_dec_t     DEC_RST = '{pass: 1'b1, in_win: 1'b0, eav_force: 1'b0, eav_clear: 1'b0};

    typedef struct packed {
        line_dec_t     dec;
        logic [DW-1:0] y;
        logic [DW-1:0] c;
    } state_t;

    state_t    st_d, st_q;
    line_dec_t new_dec;
    logic      win_hit;
    logic      cg_hit;
    logic [DW-1:0] mux_y, mux_c;

    vbi_window #(.LW(LW)) u_window (
        .line_num (line_num),
        .field    (field),
        .std      (vid_std_e'(std_sel)),
        .in_win   (win_hit),
        .cgms_line(cg_hit)
    );

    vbi_policy u_policy (
        .in_win      (win_hit),
        .cgms_line   (cg_hit),
        .std         (vid_std_e'(std_sel)),
        .tmode       (tmode_e'(timing_mode)),
        .vbi_en_hd   (vbi_en_hd),
        .vbi_en_sd   (vbi_en_sd),
        .blank_ctl_en(blank_ctl_en),
        .cgms_en     (cgms_en),
        .dec         (new_dec)
    );

    vbi_sample_mux #(.DW(DW), .BLANK_Y(BLANK_Y), .BLANK_C(BLANK_C)) u_mux (
        .pass (st_d.dec.pass),
        .y_in (in_y),
        .c_in (in_c),
        .y_out(mux_y),
        .c_out(mux_c)
    );

    always_comb begin
        st_d = st_q;
        if (line_start) st_d.dec = new_dec;
        st_d.y = mux_y;
        st_d.c = mux_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dec <= DEC_RST;
            st_q.y   <= BLANK_Y;
            st_q.c   <= BLANK_C;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_pass = st_q.dec.pass;
    assign eav_force = st_q.dec.eav_force;
    assign eav_clear = st_q.dec.eav_clear;
    assign out_y     = st_q.y;
    assign out_c     = st_q.c;

    // R2: lines outside the window are untouched
    assert_outside_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.dec.in_win |-> (line_pass && !eav_force && !eav_clear));

    // R7: force and clear are mutually exclusive
    assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(eav_force && eav_clear));

    // R10: decision holds between line boundaries
    assert_hold_midline_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(st_q.dec));

    // R9: blanked line drives blank levels one cycle later
    assert_blank_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_d.dec.pass |=> (out_y == BLANK_Y && out_c == BLANK_C));

    // R9: passed line forwards the sample one cycle later
    assert_pass_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_d.dec.pass |=> (out_y == $past(in_y) && out_c == $past(in_c)));

    // R6: clear flag only on a passing in-window line
    assert_clear_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eav_clear |-> (line_pass && st_q.dec.in_win));
endmodule

// File: tb/tb_vbi_gate.sv
`timescale 1ns/1ps
module tb_vbi_gate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        line_start;
    logic [10:0] line_num;
    logic        field;
    logic [1:0]  std_sel;
    logic        vbi_en_hd, vbi_en_sd;
    logic [1:0]  timing_mode;
    logic        blank_ctl_en, cgms_en;
    logic [7:0]  in_y, in_c;
    logic        line_pass, eav_force, eav_clear;
    logic [7:0]  out_y, out_c;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vbi_gate dut (.*);

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit e_win(int s, int l);
        case (s)
            0: return l >= 10 && l <= 20;
            1: return l >= 7  && l <= 22;
            2: return l >= 13 && l <= 42;
            default: return l >= 6 && l <= 43;
        endcase
    endfunction

    function automatic bit e_cgms(int s, int l, bit f);
        case (s)
            0: return l == 20;
            1: return l == 22 && !f;
            2: return l == 41;
            default: return l == 43;
        endcase
    endfunction

    function automatic bit e_pass(int s, int l, bit f, bit ehd, bit esd, int tm, bit bc, bit cg);
        bit on, ok;
        on = (s >= 2) ? ehd : esd;
        ok = (tm <= 1) ? on : (on && bc);
        return !e_win(s, l) || ok || (cg && e_cgms(s, l, f));
    endfunction

    task automatic run_line(string tag, int s, int l, bit f, bit ehd, bit esd,
                            int tm, bit bc, bit cg);
        bit p, w, fo, cl;
        logic [2:0] exp_flags, act_flags;
        logic [7:0] ey, ec;
        string cause;
        @(negedge clk);
        line_start = 1; line_num = 11'(l); field = f; std_sel = 2'(s);
        vbi_en_hd = ehd; vbi_en_sd = esd; timing_mode = 2'(tm);
        blank_ctl_en = bc; cgms_en = cg;
        in_y = 8'($urandom); in_c = 8'($urandom);
        w  = e_win(s, l);
        p  = e_pass(s, l, f, ehd, esd, tm, bc, cg);
        fo = w && !p;
        cl = w && p && tm == 1;
        ey = p ? in_y : 8'h10;
        ec = p ? in_c : 8'h80;
        if (!w) cause = "R2";
        else if (cl) cause = "R6";
        else if (fo) cause = ((s >= 2 ? ehd : esd) && tm >= 2) ? "R5" : "R3_R7";
        else if (cg && e_cgms(s, l, f) && !((s >= 2 ? ehd : esd) && (tm <= 1 || bc))) cause = "R8";
        else cause = "R4";
        exp_flags = {p, fo, cl};
        @(negedge clk);
        act_flags = {line_pass, eav_force, eav_clear};
        chk(act_flags == exp_flags, {tag, "/", cause}, "pass/force/clear", int'(act_flags), int'(exp_flags));
        chk(out_y == ey && out_c == ec, {tag, "/R9"}, "first sample y,c",
            int'({out_y, out_c}), int'({ey, ec}));
        // mid-line: scramble everything; decision must hold (R10)
        line_start = 0; line_num = 11'($urandom_range(0, 60)); field = ~f;
        std_sel = 2'($urandom); vbi_en_hd = ~ehd; vbi_en_sd = ~esd;
        timing_mode = 2'($urandom); blank_ctl_en = ~bc; cgms_en = ~cg;
        in_y = 8'($urandom); in_c = 8'($urandom);
        ey = p ? in_y : 8'h10;
        ec = p ? in_c : 8'h80;
        @(negedge clk);
        act_flags = {line_pass, eav_force, eav_clear};
        chk(act_flags == exp_flags, {tag, "/R10"}, "flags held midline", int'(act_flags), int'(exp_flags));
        chk(out_y == ey && out_c == ec, {tag, "/R10"}, "midline sample",
            int'({out_y, out_c}), int'({ey, ec}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; line_start = 0; line_num = 0; field = 0; std_sel = 0;
        vbi_en_hd = 1; vbi_en_sd = 1; timing_mode = 0; blank_ctl_en = 1; cgms_en = 1;
        in_y = 8'h55; in_c = 8'h66;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({line_pass, eav_force, eav_clear} == 3'b100, "R11", "reset flags",
            int'({line_pass, eav_force, eav_clear}), 4);
        chk(out_y == 8'h10 && out_c == 8'h80, "R11", "reset samples", int'({out_y, out_c}), 'h1080);
        @(negedge clk); rst_n = 1;

        // R1 window edges for each standard, all blanked by disabled VBI
        run_line("R1", 0, 9, 0, 0, 0, 0, 0, 0);
        run_line("R1", 0, 10, 0, 0, 0, 0, 0, 0);
        run_line("R1", 0, 20, 1, 0, 0, 0, 0, 0);
        run_line("R1", 0, 21, 0, 0, 0, 0, 0, 0);
        run_line("R1", 1, 6, 0, 0, 0, 0, 0, 0);
        run_line("R1", 1, 7, 0, 0, 0, 0, 0, 0);
        run_line("R1", 1, 22, 0, 0, 0, 0, 0, 0);
        run_line("R1", 1, 23, 0, 0, 0, 0, 0, 0);
        run_line("R1", 2, 12, 0, 0, 0, 0, 0, 0);
        run_line("R1", 2, 13, 0, 0, 0, 0, 0, 0);
        run_line("R1", 2, 42, 0, 0, 0, 0, 0, 0);
        run_line("R1", 2, 43, 0, 0, 0, 0, 0, 0);
        run_line("R1", 3, 5, 0, 0, 0, 0, 0, 0);
        run_line("R1", 3, 6, 0, 0, 0, 0, 0, 0);
        run_line("R1", 3, 43, 0, 0, 0, 0, 0, 0);
        run_line("R1", 3, 44, 0, 0, 0, 0, 0, 0);
        // R3 wrong enable ignored
        run_line("R3", 2, 20, 0, 0, 1, 0, 0, 0);
        run_line("R3", 0, 15, 0, 1, 0, 0, 0, 0);
        run_line("R4", 1, 12, 0, 0, 1, 0, 0, 0);
        run_line("R6", 3, 30, 0, 1, 0, 1, 0, 0);
        // R5 slave1/2 need blank control
        run_line("R5", 2, 20, 0, 1, 0, 2, 0, 0);
        run_line("R5", 2, 20, 0, 1, 0, 3, 1, 0);
        // R8 CGMS survives
        run_line("R8", 0, 20, 1, 0, 0, 2, 0, 1);
        run_line("R8", 1, 22, 0, 0, 0, 0, 0, 1);
        run_line("R8", 1, 22, 1, 0, 0, 0, 0, 1);
        run_line("R8", 2, 41, 0, 0, 0, 3, 0, 1);
        run_line("R8", 3, 43, 0, 0, 0, 1, 0, 1);
        run_line("R8", 3, 42, 0, 0, 0, 1, 0, 1);

        for (int i = 0; i < 400; i++) begin
            int s, l;
            s = $urandom_range(0, 3);
            l = (i % 3 == 0) ? ((s == 2) ? 41 : (s == 3) ? 43 : (s == 1) ? 22 : 20)
                             : $urandom_range(0, 50);
            run_line("rnd", s, l, 1'($urandom), 1'($urandom), 1'($urandom),
                     $urandom_range(0, 3), 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule